// File: doc/BRIEF.md
# Collision-Vector Initiation Scheduler

This block decides, cycle by cycle, whether a fresh operation may be launched into a shared, non-linear pipeline without two operations claiming the same stage in the same cycle. It keeps a forbidden-offset register. Each bit of that register marks a future cycle in which a launch would clash with work already in flight. Every clock the register slides one position toward bit 0. Whenever a launch is granted, the configured initial forbidden-latency pattern is merged in on top of it.

A requester raises `req` and keeps it up, or pulses it. A request that cannot be honoured at once is remembered until a grant releases it. Two admission policies are offered. The greedy policy launches at the first clash-free cycle. The fixed policy also waits until a configured minimum spacing has elapsed since the previous launch. Together they allow non-uniform repeating latency patterns such as (1,8) as well as constant ones such as (3). Alongside the grant, the block reports the register contents and a saturating count of cycles since the last launch.

Top module: `cv_scheduler`

## Requirements
- R1: During and immediately after synchronous reset, `state` is all zeros, `grant` is low while no request is present, and `latency` equals VLEN+1.
- R2: In a cycle without a grant, the next `state` is the current `state` shifted right by one place, with a zero entering at the top.
- R3: `grant` is never high while `state[0]` is 1. Bit i of `state` set means that a launch i cycles from now, counting the current cycle as 0, would clash.
- R4: In a cycle with a grant, the next `state` equals the current `state` shifted right by one, ORed with `init_vec`. Bit j of `init_vec` forbids a launch j+1 cycles after this one.
- R5: A request that is not granted in its cycle is kept pending. The pending request is granted later without `req` being raised again, and it is cleared by that grant.
- R6: With `mode` = 0 (greedy), `grant` is high in every cycle where a request is present (`req` or pending) and `state[0]` is 0.
- R7: With `mode` = 1 (fixed spacing), a grant additionally requires `latency` >= `fix_lat`.
- R8: In the cycle after a grant, `latency` is 1. It then increases by one per cycle and holds at VLEN+1.
- R9: After VLEN consecutive cycles without a grant, `state` is all zeros, so the next launch loads `init_vec` unchanged.
- R10: With `init_vec` = 1011010 (binary, bit 6 on the left) and a constant request in greedy mode, grants from reset repeat the spacings 1,8. Once a launch has been made at spacing 3 from a state of 1011011 or from 1011010, greedy operation keeps a constant spacing of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request to launch an operation |
| init_vec | input | VLEN | Initial forbidden-latency pattern; bit j forbids latency j+1 |
| mode | input | 1 | 0 = greedy, 1 = fixed minimum spacing |
| fix_lat | input | LW | Minimum spacing used in fixed mode |
| grant | output | 1 | Launch accepted in this cycle |
| state | output | VLEN | Current forbidden-offset register |
| latency | output | LW | Cycles since last grant, saturating at VLEN+1 |

LW is $clog2(VLEN+2).

## Verification
The assertions assume that `init_vec`, `mode` and `fix_lat` change only between clock edges, together with `req`, so that the values sampled at an edge are the values the grant was decided on. The bench drives every input at the falling edge, and that includes configuration changes made during random traffic. It also uses `fix_lat` values above VLEN+1, where fixed mode can never grant. In that case requests simply stay pending, which the assertions permit.

// File: rtl/cv_sched_pkg.sv
package cv_sched_pkg;

    typedef enum logic {
        SCHED_GREEDY = 1'b0,
        SCHED_FIXED  = 1'b1
    } sched_mode_e;

    typedef struct packed {
        logic want;       // live or remembered request
        logic slot_free;  // no clash in the current cycle
        logic spacing_ok; // policy spacing satisfied
    } admit_info_t;

    function automatic int lat_bits(input int vlen);
        return $clog2(vlen + 2);
    endfunction

    function automatic int lat_cap(input int vlen);
        return vlen + 1;
    endfunction

endpackage

// File: rtl/cv_state_reg.sv
module cv_state_reg #(
    parameter int VLEN = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            grant,
    input  logic [VLEN-1:0] init_vec,
    output logic [VLEN-1:0] state
);

    logic [VLEN-1:0] slid;

    always_comb begin
        slid = state >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (grant) begin
            state <= slid | init_vec;
        end else begin
            state <= slid;
        end
    end

    // R2: idle cycles only slide the register
    assert_slide_R2: assert property (@(posedge clk) disable iff (rst)
        !grant |=> (state == ($past(state) >> 1)));

endmodule

// File: rtl/cv_latency_ctr.sv
module cv_latency_ctr #(
    parameter int VLEN = 7,
    parameter int LW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant,
    output logic [LW-1:0] latency
);

    localparam logic [LW-1:0] CAP = LW'(cv_sched_pkg::lat_cap(VLEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            latency <= CAP;
        end else if (grant) begin
            latency <= LW'(1);
        end else if (latency < CAP) begin
            latency <= latency + LW'(1);
        end
    end

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        grant |=> (latency == LW'(1)));

    assert_cap_R8: assert property (@(posedge clk) disable iff (rst)
        latency <= CAP);

endmodule

// File: rtl/cv_admit.sv
module cv_admit #(
    parameter int LW = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic                     slot_busy,
    input  cv_sched_pkg::sched_mode_e mode,
    input  logic [LW-1:0]            latency,
    input  logic [LW-1:0]            fix_lat,
    output logic                     grant
);

    import cv_sched_pkg::*;

    logic        pending_q;
    admit_info_t info;

    always_comb begin
        info.want       = req | pending_q;
        info.slot_free  = ~slot_busy;
        info.spacing_ok = (mode == SCHED_GREEDY) || (latency >= fix_lat);
        grant           = info.want & info.slot_free & info.spacing_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= info.want & ~grant;
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> pending_q);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        grant |=> !pending_q);

endmodule

// File: rtl/cv_scheduler.sv
module cv_scheduler #(
    parameter  int VLEN = 7,
    localparam int LW   = $clog2(VLEN + 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [VLEN-1:0] init_vec,
    input  logic            mode,
    input  logic [LW-1:0]   fix_lat,
    output logic            grant,
    output logic [VLEN-1:0] state,
    output logic [LW-1:0]   latency
);

    import cv_sched_pkg::*;

    sched_mode_e mode_e;

    always_comb begin
        mode_e = sched_mode_e'(mode);
    end

    cv_state_reg #(.VLEN(VLEN)) u_state (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .init_vec (init_vec),
        .state    (state)
    );

    cv_latency_ctr #(.VLEN(VLEN), .LW(LW)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .grant   (grant),
        .latency (latency)
    );

    cv_admit #(.LW(LW)) u_admit (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .slot_busy (state[0]),
        .mode      (mode_e),
        .latency   (latency),
        .fix_lat   (fix_lat),
        .grant     (grant)
    );

    assert_no_clash_R3: assert property (@(posedge clk) disable iff (rst)
        grant |-> !state[0]);

    assert_merge_R4: assert property (@(posedge clk) disable iff (rst)
        grant |=> (state == (($past(state) >> 1) | $past(init_vec))));

    assert_greedy_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode && req && !state[0]) |-> grant);

    assert_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (mode && grant) |-> (latency >= fix_lat));

endmodule

// File: tb/cv_scheduler_test.sv
module cv_scheduler_test;

    localparam int VLEN   = 7;
    localparam int LW     = $clog2(VLEN + 2);
    localparam int CAP    = VLEN + 1;
    localparam int PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req = 1'b0;
    logic [VLEN-1:0] init_vec = '0;
    logic            mode = 1'b0;
    logic [LW-1:0]   fix_lat = '0;
    logic            grant;
    logic [VLEN-1:0] state;
    logic [LW-1:0]   latency;

    // configuration applied at the next falling edge
    logic [VLEN-1:0] cfg_iv   = 7'b1011010;
    logic            cfg_mode = 1'b0;
    logic [LW-1:0]   cfg_fl   = '0;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // behavioural model: list of past launches and the pattern each used
    int              g_t[$];
    logic [VLEN-1:0] g_iv[$];
    int              tnow = 0;
    int              last_g = -1;
    bit              pend_m = 0;
    bit              prev_eg = 0;
    int              obs[$];

    cv_scheduler #(.VLEN(VLEN)) uut (
        .clk(clk), .rst(rst), .req(req), .init_vec(init_vec), .mode(mode),
        .fix_lat(fix_lat), .grant(grant), .state(state), .latency(latency)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, tnow, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] exp_state();
        logic [VLEN-1:0] r = '0;
        for (int i = 0; i < VLEN; i++) begin
            for (int k = 0; k < g_t.size(); k++) begin
                int d = tnow + i - g_t[k];
                if (d >= 1 && d <= VLEN && g_iv[k][d-1]) r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic model_cycle();
        logic [VLEN-1:0] es;
        int el;
        bit eff, eg;
        es  = exp_state();
        el  = (last_g < 0) ? CAP : (((tnow - last_g) > CAP) ? CAP : (tnow - last_g));
        eff = req || pend_m;
        eg  = eff && !es[0] && (!mode || el >= int'(fix_lat));
        chk(prev_eg ? "R4 state after launch" : "R2 state slide", int'(state), int'(es));
        chk(mode ? "R7 fixed grant" : "R6 greedy grant", int'(grant), int'(eg));
        chk("R8 latency", int'(latency), el);
        if (grant) obs.push_back(tnow);
        if (eg) begin
            g_t.push_back(tnow);
            g_iv.push_back(init_vec);
            last_g = tnow;
            pend_m = 0;
        end else begin
            pend_m = eff;
        end
        prev_eg = eg;
        tnow++;
        while (g_t.size() > 0 && (tnow - g_t[0]) > VLEN + 1) begin
            void'(g_t.pop_front());
            void'(g_iv.pop_front());
        end
    endtask

    task automatic step(input logic r);
        @(negedge clk);
        req = r;
        init_vec = cfg_iv;
        mode = cfg_mode;
        fix_lat = cfg_fl;
        #1;
        model_cycle();
    endtask

    task automatic check_gaps(input string tag, input int first_idx, input int n,
                              input int g_even, input int g_odd);
        for (int k = 0; k < n; k++) begin
            int gap = obs[first_idx + k + 1] - obs[first_idx + k];
            chk(tag, gap, (k % 2 == 0) ? g_even : g_odd);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (4) @(negedge clk);
        init_vec = cfg_iv;
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset values
        chk("R1 state after reset", int'(state), 0);
        chk("R1 latency after reset", int'(latency), CAP);
        chk("R1 grant idle", int'(grant), 0);
        model_cycle();

        // R10: greedy from reset with 1011010 gives 1,8,1,8
        obs.delete();
        repeat (20) step(1'b1);
        chk("R10 grant count", obs.size(), 6);
        if (obs.size() >= 6) check_gaps("R10 greedy 1,8 cycle", 0, 5, 1, 8);

        // R9 and R8: idle long enough clears state, saturates latency
        repeat (VLEN + 3) step(1'b0);
        chk("R9 state cleared", int'(state), 0);
        chk("R8 latency saturated", int'(latency), CAP);

        // R5: blocked pulse is remembered and granted later
        step(1'b1);
        step(1'b0);
        step(1'b1);
        chk("R5 blocked pulse not granted", int'(grant), 0);
        step(1'b0);
        chk("R5 pending request granted", int'(grant), 1);
        repeat (VLEN + 3) step(1'b0);

        // R7: fixed spacing 3, then greedy keeps 3 (R10)
        cfg_mode = 1'b1;
        cfg_fl = LW'(3);
        obs.delete();
        repeat (13) step(1'b1);
        chk("R7 fixed grant count", obs.size(), 5);
        if (obs.size() >= 5) check_gaps("R7 fixed spacing 3", 0, 4, 3, 3);
        cfg_mode = 1'b0;
        obs.delete();
        repeat (12) step(1'b1);
        chk("R10 greedy count after 3", obs.size(), 4);
        if (obs.size() >= 4) check_gaps("R10 greedy keeps 3", 0, 3, 3, 3);
        repeat (VLEN + 3) step(1'b0);

        // R7: fixed spacing 6
        cfg_mode = 1'b1;
        cfg_fl = LW'(6);
        obs.delete();
        repeat (19) step(1'b1);
        if (obs.size() >= 3) check_gaps("R7 fixed spacing 6", 0, 2, 6, 6);
        else chk("R7 fixed spacing 6 count", obs.size(), 3);
        repeat (VLEN + 3) step(1'b0);

        // R6: second pattern 0001010, greedy
        cfg_mode = 1'b0;
        cfg_iv = 7'b0001010;
        repeat (20) step(1'b1);
        repeat (VLEN + 3) step(1'b0);

        // mixed random traffic, all requirements checked each cycle by the model
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 50 == 0) begin
                case (lfsr[1:0])
                    2'd0: cfg_iv = 7'b1011010;
                    2'd1: cfg_iv = 7'b0001010;
                    2'd2: cfg_iv = 7'b1100101;
                    default: cfg_iv = 7'b0100110;
                endcase
            end
            if (n % 37 == 0) cfg_mode = lfsr[5];
            if (n % 29 == 0) cfg_fl = LW'(lfsr[9:6] % 11);
            step(lfsr[3] | lfsr[7]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule